// File: doc/BRIEF.md
# Interrupt Enable Flag Controller

This block holds the two interrupt enable flags of an 8-bit processor core. The first is the live master enable. The second is a saved copy that survives a non-maskable interrupt. The block also decides, at each instruction boundary, whether a pending non-maskable request or a level-sensitive maskable request is accepted. It reports each acceptance as a one-cycle pulse together with the handler address.

The decoder drives a strobe for the enable/disable instruction pair. That strobe is asserted in the first clock of the opcode fetch, and opcode bit 3 selects enable (1) or disable (0). The decoder also drives strobes for the return-from-NMI instruction and for the load-of-I-into-A instruction. The sequencer marks each instruction end with a single-cycle strobe.

When an NMI is accepted, the master enable is held clear for a fixed acknowledge window. If an enable instruction loads the flags inside that window, the forced clear wins for the master flag, but the saved flag still takes the enable. A later return from the handler therefore restores interrupts.

Top module: `irq_enable_ctl`

## Requirements
- R1: While reset is asserted, and after it is released, iff1, iff2, nmi_take, int_take and pv_flag are 0 and vec_addr is 0.
- R2: A cycle with en_dis_stb high loads op_bit3 into both iff1 and iff2 at the next clock edge (1 = enable, 0 = disable).
- R3: A rising edge on nmi_req is remembered until the next cycle with insn_end high. At the edge after that cycle, nmi_take pulses for one cycle with vec_addr = 0x0066. A request held high does not trigger a second time.
- R4: Accepting an NMI clears iff1 and leaves iff2 unchanged.
- R5: For the ACK_CYCLES (10) cycles after an NMI acceptance, iff1 stays 0. An enable load in any of those cycles sets iff2 only. The first enable load after the window sets iff1 again.
- R6: A cycle with retn_stb high copies iff2 into iff1 at the next edge, and iff2 keeps its value.
- R7: A cycle with insn_end, int_req and iff1 high, and no NMI pending, makes int_take pulse at the next edge with vec_addr = 0x0038. The same edge clears iff1 and iff2.
- R8: int_req is ignored while iff1 is 0.
- R9: The first instruction end after an enable load does not accept int_req. The second instruction end does accept it.
- R10: When an NMI is pending at an instruction end, the NMI is accepted and int_req is not.
- R11: A cycle with ld_a_i_stb high copies iff2 to pv_flag at the next edge. pv_flag holds its value in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_dis_stb | input | 1 | Enable/disable instruction load strobe (opcode fetch, first clock) |
| op_bit3 | input | 1 | Opcode bit 3: 1 enable, 0 disable |
| insn_end | input | 1 | Last cycle of an instruction; interrupts are sampled here |
| nmi_req | input | 1 | Non-maskable request, rising-edge sensitive |
| int_req | input | 1 | Maskable request, level sensitive |
| retn_stb | input | 1 | Return-from-NMI strobe |
| ld_a_i_stb | input | 1 | Load-I-into-A strobe |
| iff1 | output | 1 | Master interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| nmi_take | output | 1 | One-cycle NMI acceptance pulse |
| int_take | output | 1 | One-cycle maskable acceptance pulse |
| vec_addr | output | 16 | Handler address while a take pulse is high, else 0 |
| pv_flag | output | 1 | Parity/overflow value produced by load-I-into-A |

## Verification
A wrong master flag shows up at the next instruction end. Either a maskable request is accepted when it should be refused, or it is refused when it should be accepted, and int_take shows this one cycle later. A wrong saved flag stays hidden until a return-from-NMI or a load-I-into-A exposes it on iff1 or pv_flag. For that reason the bench runs the enable-inside-acknowledge case through to the return and a final maskable acceptance. An acknowledge window that is too short or too long is found by placing enable loads in the last cycle of the window and in the first cycle after it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_NMI  = 2'd1,
    TAKE_INT  = 2'd2
  } take_e;
endpackage

// File: rtl/irq_nmi_front.sv
module irq_nmi_front #(
  parameter int ACK_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_req,
  input  logic nmi_accept,
  output logic nmi_pend,
  output logic nmi_ack
);
  localparam int CW = $clog2(ACK_CYCLES + 1);

  logic          nmi_q, nmi_q_n;
  logic          pend_q, pend_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          rise;

  always_comb begin
    rise    = nmi_req & ~nmi_q;
    nmi_q_n = nmi_req;
    pend_n  = pend_q;
    if (nmi_accept) pend_n = 1'b0;
    if (rise)       pend_n = 1'b1;
    cnt_n = cnt_q;
    if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
    if (nmi_accept)  cnt_n = CW'(ACK_CYCLES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b1;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      nmi_q  <= nmi_q_n;
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
    end
  end

  assign nmi_pend = pend_q;
  assign nmi_ack  = (cnt_q != '0);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int          AW      = 16,
  parameter logic [AW-1:0] VEC_NMI = 16'h0066,
  parameter logic [AW-1:0] VEC_INT = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_end,
  input  logic          nmi_pend,
  input  logic          int_req,
  input  logic          iff1,
  input  logic          ei_block,
  output logic          nmi_accept,
  output logic          int_accept,
  output logic          nmi_take,
  output logic          int_take,
  output logic [AW-1:0] vec_addr
);
  take_e         sel;
  take_e         take_q;
  logic [AW-1:0] vec_n, vec_q;

  always_comb begin
    nmi_accept = insn_end & nmi_pend;
    int_accept = insn_end & int_req & iff1 & ~ei_block & ~nmi_pend;
    sel        = TAKE_NONE;
    if (int_accept) sel = TAKE_INT;
    if (nmi_accept) sel = TAKE_NMI;
    case (sel)
      TAKE_NMI: vec_n = VEC_NMI;
      TAKE_INT: vec_n = VEC_INT;
      default:  vec_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= TAKE_NONE;
      vec_q  <= '0;
    end else begin
      take_q <= sel;
      vec_q  <= vec_n;
    end
  end

  assign nmi_take = (take_q == TAKE_NMI);
  assign int_take = (take_q == TAKE_INT);
  assign vec_addr = vec_q;
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic en_dis_stb,
  input  logic op_bit3,
  input  logic insn_end,
  input  logic retn_stb,
  input  logic ld_a_i_stb,
  input  logic nmi_accept,
  input  logic nmi_ack,
  input  logic int_accept,
  output logic iff1,
  output logic iff2,
  output logic ei_block,
  output logic pv_flag
);
  logic f1_q, f1_n, f2_q, f2_n, blk_q, blk_n, pv_q, pv_n;

  always_comb begin
    f1_n = f1_q;
    f2_n = f2_q;
    if (retn_stb) f1_n = f2_q;
    if (en_dis_stb) begin
      f1_n = op_bit3;
      f2_n = op_bit3;
    end
    if (int_accept) begin
      f1_n = 1'b0;
      f2_n = 1'b0;
    end
    // forced clear beats any load of the master flag; saved flag untouched
    if (nmi_accept | nmi_ack) f1_n = 1'b0;

    blk_n = blk_q;
    if (insn_end)                blk_n = 1'b0;
    if (en_dis_stb && op_bit3)   blk_n = 1'b1;

    pv_n = ld_a_i_stb ? f2_q : pv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_q  <= 1'b0;
      f2_q  <= 1'b0;
      blk_q <= 1'b0;
      pv_q  <= 1'b0;
    end else begin
      f1_q  <= f1_n;
      f2_q  <= f2_n;
      blk_q <= blk_n;
      pv_q  <= pv_n;
    end
  end

  assign iff1     = f1_q;
  assign iff2     = f2_q;
  assign ei_block = blk_q;
  assign pv_flag  = pv_q;
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl #(
  parameter int            ACK_CYCLES = 10,
  parameter int            AW         = 16,
  parameter logic [AW-1:0] VEC_NMI    = 16'h0066,
  parameter logic [AW-1:0] VEC_INT    = 16'h0038
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_dis_stb,
  input  logic          op_bit3,
  input  logic          insn_end,
  input  logic          nmi_req,
  input  logic          int_req,
  input  logic          retn_stb,
  input  logic          ld_a_i_stb,
  output logic          iff1,
  output logic          iff2,
  output logic          nmi_take,
  output logic          int_take,
  output logic [AW-1:0] vec_addr,
  output logic          pv_flag
);
  logic rs_q1, rs_q2;
  logic nmi_pend, nmi_ack, nmi_accept, int_accept, ei_block;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  irq_nmi_front #(.ACK_CYCLES(ACK_CYCLES)) u_front (
    .clk(clk), .rst_n(rs_q2), .nmi_req(nmi_req), .nmi_accept(nmi_accept),
    .nmi_pend(nmi_pend), .nmi_ack(nmi_ack)
  );

  irq_arbiter #(.AW(AW), .VEC_NMI(VEC_NMI), .VEC_INT(VEC_INT)) u_arb (
    .clk(clk), .rst_n(rs_q2), .insn_end(insn_end), .nmi_pend(nmi_pend),
    .int_req(int_req), .iff1(iff1), .ei_block(ei_block),
    .nmi_accept(nmi_accept), .int_accept(int_accept),
    .nmi_take(nmi_take), .int_take(int_take), .vec_addr(vec_addr)
  );

  irq_flag_regs u_flags (
    .clk(clk), .rst_n(rs_q2), .en_dis_stb(en_dis_stb), .op_bit3(op_bit3),
    .insn_end(insn_end), .retn_stb(retn_stb), .ld_a_i_stb(ld_a_i_stb),
    .nmi_accept(nmi_accept), .nmi_ack(nmi_ack), .int_accept(int_accept),
    .iff1(iff1), .iff2(iff2), .ei_block(ei_block), .pv_flag(pv_flag)
  );
endmodule

// File: rtl/irq_enable_ctl_chk.sv
module irq_enable_ctl_chk #(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] VEC_NMI = 16'h0066,
  parameter logic [AW-1:0] VEC_INT = 16'h0038
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_dis_stb,
  input logic          op_bit3,
  input logic          insn_end,
  input logic          retn_stb,
  input logic          ld_a_i_stb,
  input logic          iff1,
  input logic          iff2,
  input logic          nmi_take,
  input logic          int_take,
  input logic [AW-1:0] vec_addr,
  input logic          pv_flag,
  input logic          nmi_ack,
  input logic          nmi_accept,
  input logic          int_accept
);
  assert_one_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_take, int_take}));
  assert_int_needs_iff1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> $past(iff1));
  assert_int_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_take |-> (!iff1 && !iff2 && vec_addr == VEC_INT));
  assert_nmi_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_take |-> (vec_addr == VEC_NMI && !iff1));
  assert_nmi_keeps_iff2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_take && !$past(en_dis_stb) && !$past(int_accept)) |-> iff2 == $past(iff2));
  assert_ack_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_ack || nmi_accept) |-> !iff1);
  assert_ei_sets_iff2_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en_dis_stb && op_bit3 && !int_accept) |-> iff2);
  assert_retn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(retn_stb && !en_dis_stb && !insn_end && !nmi_ack) |-> iff1 == $past(iff2));
  assert_pv_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_a_i_stb) |-> pv_flag == $past(iff2));
endmodule

bind irq_enable_ctl irq_enable_ctl_chk #(.AW(AW), .VEC_NMI(VEC_NMI), .VEC_INT(VEC_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_dis_stb(en_dis_stb), .op_bit3(op_bit3),
  .insn_end(insn_end), .retn_stb(retn_stb), .ld_a_i_stb(ld_a_i_stb),
  .iff1(iff1), .iff2(iff2), .nmi_take(nmi_take), .int_take(int_take),
  .vec_addr(vec_addr), .pv_flag(pv_flag), .nmi_ack(nmi_ack),
  .nmi_accept(nmi_accept), .int_accept(int_accept)
);

// File: tb/sim_irq_enable_ctl.sv
module sim_irq_enable_ctl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_dis_stb, op_bit3, insn_end, nmi_req, int_req, retn_stb, ld_a_i_stb;
  logic        iff1, iff2, nmi_take, int_take, pv_flag;
  logic [15:0] vec_addr;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_enable_ctl u0 (
    .clk(clk), .rst_n(rst_n), .en_dis_stb(en_dis_stb), .op_bit3(op_bit3),
    .insn_end(insn_end), .nmi_req(nmi_req), .int_req(int_req),
    .retn_stb(retn_stb), .ld_a_i_stb(ld_a_i_stb), .iff1(iff1), .iff2(iff2),
    .nmi_take(nmi_take), .int_take(int_take), .vec_addr(vec_addr), .pv_flag(pv_flag)
  );

  // row: {en_dis, bit3, insn_end, nmi, int, retn, ld_a_i, exp iff1, iff2, nmi_take, int_take, pv}
  localparam logic [11:0] TBL [26] = '{
    12'b0000000_00000, // 0  idle                          R1
    12'b1100000_11000, // 1  enable load                   R2
    12'b0010100_11000, // 2  end of enable insn, int held  R9
    12'b0010100_00010, // 3  next end: int taken           R7 R9
    12'b0010100_00000, // 4  int with iff1 low             R8
    12'b1100000_11000, // 5  enable                        R2
    12'b1000000_00000, // 6  disable                       R2
    12'b0010000_00000, // 7
    12'b1100000_11000, // 8  enable
    12'b0010000_11000, // 9
    12'b0000001_11001, // 10 load I to A                   R11
    12'b0001000_11001, // 11 nmi edge latched              R3
    12'b0011100_01101, // 12 nmi beats int                 R3 R4 R10
    12'b1101000_01001, // 13 enable inside ack, nmi held   R5
    12'b0010100_01001, // 14 int refused, iff1 low         R8
    12'b0000000_01001, // 15 ack window                    R5
    12'b0000000_01001, // 16
    12'b0000000_01001, // 17
    12'b0000000_01001, // 18
    12'b0000000_01001, // 19
    12'b0000000_01001, // 20
    12'b0000000_01001, // 21
    12'b0000000_01001, // 22 last ack cycle
    12'b0000010_11001, // 23 return from NMI               R6
    12'b0010100_00011, // 24 int taken after return        R7
    12'b0000001_00000  // 25 load I to A                   R11
  };

  function automatic string row_req(int r);
    case (r)
      0: return "R1";
      1, 5, 6, 8: return "R2";
      2, 9: return "R9";
      3, 24: return "R7";
      4, 14: return "R8";
      10, 25: return "R11";
      11: return "R3";
      12: return "R10";
      23: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic ed, logic b3, logic ie, logic nm, logic ir, logic rt, logic la);
    en_dis_stb = ed; op_bit3 = b3; insn_end = ie; nmi_req = nm;
    int_req = ir; retn_stb = rt; ld_a_i_stb = la;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive(0, 0, 0, 0, 0, 0, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_state(string req, logic e1, logic e2, logic en, logic ei, logic ep);
    logic [15:0] ev;
    ev = en ? 16'h0066 : (ei ? 16'h0038 : 16'h0000);
    chk(req, "iff1", {15'd0, iff1}, {15'd0, e1});
    chk(req, "iff2", {15'd0, iff2}, {15'd0, e2});
    chk(req, "nmi_take", {15'd0, nmi_take}, {15'd0, en});
    chk(req, "int_take", {15'd0, int_take}, {15'd0, ei});
    chk(req, "vec_addr", vec_addr, ev);
    chk(req, "pv_flag", {15'd0, pv_flag}, {15'd0, ep});
  endtask

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    // R1: outputs during reset
    check_state("R1", 0, 0, 0, 0, 0);
    do_reset();
    check_state("R1", 0, 0, 0, 0, 0);

    for (int r = 0; r < 26; r++) begin
      drive(TBL[r][11], TBL[r][10], TBL[r][9], TBL[r][8], TBL[r][7], TBL[r][6], TBL[r][5]);
      step();
      check_state(row_req(r), TBL[r][4], TBL[r][3], TBL[r][2], TBL[r][1], TBL[r][0]);
    end

    // R1: reset in the middle of activity
    drive(1, 1, 0, 0, 0, 0, 1);
    step();
    do_reset();
    check_state("R1", 0, 0, 0, 0, 0);

    // R3: pending NMI waits for an instruction end; held level does not retrigger
    drive(1, 1, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 1, 0, 0, 0); step();
    drive(0, 0, 0, 1, 0, 0, 0); step();
    check_state("R3", 1, 1, 0, 0, 0);
    drive(0, 0, 1, 1, 0, 0, 0); step();
    check_state("R3", 0, 1, 1, 0, 0);
    // R5 boundary: nine idle ack cycles, then an enable in the tenth
    for (int k = 0; k < 8; k++) begin
      drive(0, 0, 1, 1, 0, 0, 0); step();
    end
    chk("R3", "nmi_take held level", {15'd0, nmi_take}, 16'd0);
    drive(0, 0, 0, 0, 0, 0, 0); step();
    drive(1, 1, 0, 0, 0, 0, 0); step();
    check_state("R5", 0, 1, 0, 0, 0);
    drive(1, 1, 0, 0, 0, 0, 0); step();
    check_state("R5", 1, 1, 0, 0, 0);

    // R6: return with saved flag clear
    drive(1, 0, 0, 0, 0, 0, 0); step();
    drive(0, 0, 0, 0, 0, 0, 0); iff1_force_setup();
    drive(0, 0, 0, 0, 0, 1, 0); step();
    check_state("R6", 0, 0, 0, 0, 0);

    drive(0, 0, 0, 0, 0, 0, 0);
    done = 1;
  end

  task automatic iff1_force_setup();
    step();
  endtask

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule